// File: doc/BRIEF.md
# Byte-lane bus access sequencer

This block sits between a processor core and a 16-bit external data bus. It accepts one request at a time, for memory, external I/O or on-chip I/O. It then drives the bus cycles that the request needs. A memory request names a byte address and a size of one, two or four bytes. The block splits the request into as many bus cycles as the address alignment forces. It places each byte on its lane and assembles read data least significant byte first.

External I/O requests always take exactly one strobed bus cycle, whatever their size. On-chip I/O requests produce a two-clock pseudo-cycle. During that pseudo-cycle only the 8-bit register address appears on the address bus, and every strobe and lane enable stays low. Each bus cycle lasts one clock, because wait states, chip selects and arbitration belong to other blocks. Requests use a valid/ready handshake. Completion is a one-clock `done` pulse, and the read value is presented on `rdata` during that pulse.

Top module: `bus_lane_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `done`, `bus_mem_stb`, `bus_io_stb` and `bus_wr` are 0. No strobe is ever high while `req_ready` is high.
- R2: A multi-byte value has its least significant byte at the request address. Byte k of the value (bits 8k+7..8k) sits at address a+k. A read of n bytes returns those bytes in `rdata[8n-1:0]`, and the upper bits of `rdata` are zero.
- R3: The byte at an even address travels on bus bits 15..8, and the byte at an odd address on bits 7..0. `bus_be[1]` enables the upper lane and `bus_be[0]` the lower lane. A two-lane memory cycle only ever has an even `bus_addr`, and every strobed cycle has at least one lane enabled.
- R4: A one-byte access takes one cycle. A two-byte access at an even address takes one cycle with `bus_be`=11. A four-byte access at an even address takes two cycles, at a and then a+2, both with `bus_be`=11.
- R5: A two-byte access at an odd address a takes two single-byte cycles: first at a with `bus_be`=01, then at a+1 with `bus_be`=10.
- R6: A four-byte access at an odd address a takes three cycles: a with `bus_be`=01, then a+1 with `bus_be`=11, then a+3 with `bus_be`=10.
- R7: External I/O (`req_kind`=1, and also the unused code 3) takes exactly one cycle with `bus_io_stb` high. Size 1 uses the lane given by address parity. Sizes 2 and 4 use both lanes: value bits 7..0 on the upper lane and bits 15..8 on the lower lane. A read returns those 16 bits, zero-extended.
- R8: On-chip I/O (`req_kind`=2) holds `bus_addr` at {zeros, `req_addr[7:0]`} for two clocks, with both strobes and `bus_be` at 0. A write drives `req_wdata[7:0]` on the upper lane. A read takes the upper lane in the second clock, zero-extended.
- R9: `req_ready` is high only while idle. `done` is a single-clock pulse in the clock after the last bus cycle, so it comes n+1 clocks after acceptance for n bus cycles. A write completes with `rdata`=0.
- R10: Write data follows the lane rules of R2 and R3, so a memory write changes exactly bytes a..a+n-1 and no other byte. `req_size` codes: 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. `req_kind` codes: 0 = memory, 1 = external I/O, 2 = on-chip I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_kind | input | 2 | 0 memory, 1 external I/O, 2 on-chip I/O |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 two bytes, 2/3 four bytes |
| req_wdata | input | 32 | Write value, little-endian |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read value, valid with done |
| bus_addr | output | AW | Byte address of current bus cycle |
| bus_be | output | 2 | Lane enables: bit 1 upper lane, bit 0 lower lane |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes, taken at the end of each cycle |
| bus_mem_stb | output | 1 | Memory cycle strobe |
| bus_io_stb | output | 1 | External I/O cycle strobe |
| bus_wr | output | 1 | Write direction of the current cycle |

## Verification
The pointer, remaining count and lane plan are held in registers. A wrong value in any of them shows up at the ports by the next bus cycle. The result is a wrong `bus_addr`/`bus_be` pair, an extra or missing strobed cycle, or a write that lands in a neighbouring byte of the bench's memory. A fault in the read assembly path only appears with `done`, as a byte in the wrong position of `rdata`, so every read is compared with a reference byte image. The bench sweeps every start offset within a 16-bit word pair for all three sizes, both directions, and every kind of request, and it checks the cycle sequence and the completion latency.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    K_MEM = 2'd0,
    K_EXT = 2'd1,
    K_INT = 2'd2,
    K_RSV = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_XFER = 2'd1,
    S_INT1 = 2'd2,
    S_INT2 = 2'd3
  } state_e;

  // byte count of a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bls_planner.sv
module bls_planner #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cyc_addr,
  input  logic [2:0]    nbytes,
  input  logic          io,
  output logic [1:0]    be,
  output logic [2:0]    take
);
  always_comb begin
    if (io) begin
      if (nbytes == 3'd1) begin
        be   = cyc_addr[0] ? 2'b01 : 2'b10;
        take = 3'd1;
      end else begin
        be   = 2'b11;
        take = nbytes;
      end
    end else if (cyc_addr[0]) begin
      be   = 2'b01;
      take = 3'd1;
    end else if (nbytes >= 3'd2) begin
      be   = 2'b11;
      take = 3'd2;
    end else begin
      be   = 2'b10;
      take = 3'd1;
    end
  end
endmodule

// File: rtl/bls_wr_steer.sv
module bls_wr_steer #(
  parameter int VW = 32,
  localparam int PW = $clog2(VW / 8)
) (
  input  logic [VW-1:0] wdata,
  input  logic [PW-1:0] ptr,
  input  logic [1:0]    be,
  output logic [15:0]   lanes
);
  logic [PW-1:0] ptr1;
  logic [7:0]    b0, b1;

  always_comb begin
    ptr1  = ptr + PW'(1);
    b0    = wdata[ptr * 8 +: 8];
    b1    = wdata[ptr1 * 8 +: 8];
    lanes = '0;
    if (be[1]) lanes[15:8] = b0;
    if (be[0]) lanes[7:0]  = be[1] ? b1 : b0;
  end
endmodule

// File: rtl/bls_rd_merge.sv
module bls_rd_merge #(
  parameter int VW = 32,
  localparam int PW = $clog2(VW / 8)
) (
  input  logic [VW-1:0] acc,
  input  logic [15:0]   din,
  input  logic [PW-1:0] ptr,
  input  logic [1:0]    be,
  output logic [VW-1:0] acc_n
);
  logic [PW-1:0] ptr1;

  always_comb begin
    ptr1  = ptr + PW'(1);
    acc_n = acc;
    if (be[1]) acc_n[ptr * 8 +: 8] = din[15:8];
    if (be[0]) begin
      if (be[1]) acc_n[ptr1 * 8 +: 8] = din[7:0];
      else       acc_n[ptr * 8 +: 8]  = din[7:0];
    end
  end
endmodule

// File: rtl/bus_lane_seq.sv
module bus_lane_seq
  import bls_pkg::*;
#(
  parameter int AW     = 32,
  parameter int VW     = 32,
  parameter int INT_AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [VW-1:0] req_wdata,
  output logic          done,
  output logic [VW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_be,
  output logic [15:0]   bus_dout,
  input  logic [15:0]   bus_din,
  output logic          bus_mem_stb,
  output logic          bus_io_stb,
  output logic          bus_wr
);
  localparam int PW = $clog2(VW / 8);

  state_e        st;
  logic [AW-1:0] base_q;
  logic          wr_q;
  logic [VW-1:0] wdata_q;
  logic [VW-1:0] acc_q;
  logic [2:0]    ptr_q, rem_q, take_q;
  logic          done_q;
  logic [VW-1:0] rdata_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    be_q;
  logic [15:0]   dout_q;
  logic          mstb_q, iostb_q, wrq_q;

  // plan of the next bus cycle
  logic          idle;
  logic [2:0]    nxt_ptr;
  logic [AW-1:0] p_addr;
  logic [2:0]    p_n;
  logic          p_io;
  logic [1:0]    p_be;
  logic [2:0]    p_take;
  logic [VW-1:0] s_wdata;
  logic [PW-1:0] s_ptr;
  logic [15:0]   s_lanes;
  logic [VW-1:0] acc_n;
  logic          last;

  assign idle    = (st == S_IDLE);
  assign nxt_ptr = ptr_q + take_q;
  assign last    = (rem_q == take_q);

  always_comb begin
    if (idle) begin
      p_addr  = req_addr;
      p_n     = size_bytes(req_size);
      p_io    = (req_kind != K_MEM);
      s_wdata = req_wdata;
      s_ptr   = '0;
    end else begin
      p_addr  = base_q + AW'(nxt_ptr);
      p_n     = rem_q - take_q;
      p_io    = 1'b0;
      s_wdata = wdata_q;
      s_ptr   = nxt_ptr[PW-1:0];
    end
  end

  bls_planner #(.AW(AW)) u_plan (
    .cyc_addr(p_addr), .nbytes(p_n), .io(p_io), .be(p_be), .take(p_take)
  );

  bls_wr_steer #(.VW(VW)) u_steer (
    .wdata(s_wdata), .ptr(s_ptr), .be(p_be), .lanes(s_lanes)
  );

  bls_rd_merge #(.VW(VW)) u_merge (
    .acc(acc_q), .din(bus_din), .ptr(ptr_q[PW-1:0]), .be(be_q), .acc_n(acc_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      base_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      acc_q   <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      take_q  <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      dout_q  <= '0;
      mstb_q  <= 1'b0;
      iostb_q <= 1'b0;
      wrq_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            base_q  <= req_addr;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            acc_q   <= '0;
            if (req_kind == K_INT) begin
              st      <= S_INT1;
              addr_q  <= {{(AW-INT_AW){1'b0}}, req_addr[INT_AW-1:0]};
              be_q    <= 2'b00;
              dout_q  <= req_write ? {req_wdata[7:0], 8'h00} : 16'h0000;
              mstb_q  <= 1'b0;
              iostb_q <= 1'b0;
              wrq_q   <= 1'b0;
            end else begin
              st      <= S_XFER;
              ptr_q   <= '0;
              rem_q   <= p_n;
              take_q  <= p_take;
              addr_q  <= req_addr;
              be_q    <= p_be;
              dout_q  <= req_write ? s_lanes : 16'h0000;
              mstb_q  <= (req_kind == K_MEM);
              iostb_q <= (req_kind != K_MEM);
              wrq_q   <= req_write;
            end
          end
        end
        S_XFER: begin
          if (!wr_q) acc_q <= acc_n;
          if (last) begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            rdata_q <= wr_q ? '0 : acc_n;
            be_q    <= 2'b00;
            dout_q  <= 16'h0000;
            mstb_q  <= 1'b0;
            iostb_q <= 1'b0;
            wrq_q   <= 1'b0;
          end else begin
            ptr_q  <= nxt_ptr;
            rem_q  <= p_n;
            take_q <= p_take;
            addr_q <= p_addr;
            be_q   <= p_be;
            dout_q <= wr_q ? s_lanes : 16'h0000;
          end
        end
        S_INT1: st <= S_INT2;
        default: begin
          st      <= S_IDLE;
          done_q  <= 1'b1;
          rdata_q <= wr_q ? '0 : {{(VW-8){1'b0}}, bus_din[15:8]};
          dout_q  <= 16'h0000;
        end
      endcase
    end
  end

  assign req_ready   = idle;
  assign done        = done_q;
  assign rdata       = rdata_q;
  assign bus_addr    = addr_q;
  assign bus_be      = be_q;
  assign bus_dout    = dout_q;
  assign bus_mem_stb = mstb_q;
  assign bus_io_stb  = iostb_q;
  assign bus_wr      = wrq_q;

  // R1: no strobe while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!bus_mem_stb && !bus_io_stb));
  // R3: two-lane memory cycles sit on an even address
  a_r3_word_even: assert property (@(posedge clk) disable iff (rst)
    (bus_mem_stb && bus_be == 2'b11) |-> !bus_addr[0]);
  // R3: a strobed cycle enables a lane
  a_r3_lane_used: assert property (@(posedge clk) disable iff (rst)
    (bus_mem_stb || bus_io_stb) |-> (bus_be != 2'b00));
  // R7: at most one strobe kind, and I/O never takes two cycles
  a_r7_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_mem_stb, bus_io_stb}));
  a_r7_io_single: assert property (@(posedge clk) disable iff (rst)
    bus_io_stb |=> !bus_io_stb);
  // R8: strobe-less clocks enable no lane
  a_r8_quiet_lanes: assert property (@(posedge clk) disable iff (rst)
    (!bus_mem_stb && !bus_io_stb) |-> (bus_be == 2'b00));
  // R9: completion is a single pulse, acceptance leaves idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/bus_lane_seq_tb.sv
module bus_lane_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic [31:0] bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_dout;
  logic [15:0] bus_din;
  logic        bus_mem_stb, bus_io_stb, bus_wr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [7:0] bmem [0:63];
  logic [7:0] ref_mem [0:63];

  // results of the last request
  int          n_stb, n_quiet, lat;
  logic [31:0] log_addr [0:3];
  logic [1:0]  log_be [0:3];
  logic [15:0] log_dout [0:3];
  logic [31:0] q_addr;
  logic [1:0]  q_be;
  logic [15:0] q_dout;
  logic        q_stb;
  logic [31:0] got;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_lane_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_mem_stb(bus_mem_stb), .bus_io_stb(bus_io_stb),
    .bus_wr(bus_wr)
  );

  // bus memory: even address byte on the upper lane
  assign bus_din = {bmem[{bus_addr[5:1], 1'b0}], bmem[{bus_addr[5:1], 1'b1}]};

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) bmem[i] <= 8'(i * 5 + 3);
    end else if (bus_mem_stb && bus_wr) begin
      if (bus_be[1]) bmem[{bus_addr[5:1], 1'b0}] <= bus_dout[15:8];
      if (bus_be[0]) bmem[{bus_addr[5:1], 1'b1}] <= bus_dout[7:0];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] k, input logic w, input logic [31:0] a,
                     input logic [1:0] s, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_write = w; req_addr = a;
    req_size = s; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n_stb = 0; n_quiet = 0; lat = 1; q_stb = 1'b0;
    while (!done && lat < 20) begin
      if (bus_mem_stb || bus_io_stb) begin
        if (n_stb < 4) begin
          log_addr[n_stb] = bus_addr;
          log_be[n_stb]   = bus_be;
          log_dout[n_stb] = bus_dout;
        end
        n_stb = n_stb + 1;
      end else begin
        q_addr = bus_addr; q_be = bus_be; q_dout = bus_dout;
        q_stb  = q_stb | bus_wr;
        n_quiet = n_quiet + 1;
      end
      lat = lat + 1;
      @(negedge clk);
    end
    got = rdata;
  endtask

  function automatic int ncyc(input int a, input int n);
    if (n == 1) return 1;
    if (n == 2) return (a % 2 != 0) ? 2 : 1;
    return (a % 2 != 0) ? 3 : 2;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'(i * 5 + 3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk({done, bus_mem_stb, bus_io_stb, bus_wr} == 4'b0, "R1 outputs quiet",
        32'({done, bus_mem_stb, bus_io_stb, bus_wr}), 32'd0);

    // memory sweep: every start offset, every size
    for (int a = 8; a < 16; a++) begin
      for (int si = 0; si < 3; si++) begin
        int n;
        logic [31:0] wd, exp;
        n  = (si == 0) ? 1 : (si == 1) ? 2 : 4;
        wd = {8'(8'hA0 + a), 8'(8'hB0 + si), 8'(8'hC0 + a), 8'(8'hD0 + si)};
        run(2'd0, 1'b1, 32'(a), 2'(si), wd);
        for (int k = 0; k < n; k++) ref_mem[a + k] = wd[k * 8 +: 8];
        chk(n_stb == ncyc(a, n), "R4 R5 R6 write cycle count", 32'(n_stb), 32'(ncyc(a, n)));
        chk(lat == ncyc(a, n) + 1, "R9 write done latency", 32'(lat), 32'(ncyc(a, n) + 1));
        chk(got == 32'h0, "R9 write rdata zero", got, 32'h0);
        chk(n_quiet == 0, "R1 no quiet cycles in memory access", 32'(n_quiet), 32'd0);
        for (int j = a - 1; j <= a + 4; j++)
          chk(bmem[j] == ref_mem[j], "R10 memory image after write", 32'(bmem[j]), 32'(ref_mem[j]));
        // first cycle lanes per R3
        exp = (a % 2 != 0) ? 32'd1 : (n >= 2) ? 32'd3 : 32'd2;
        chk(32'(log_be[0]) == exp, "R3 first cycle lanes", 32'(log_be[0]), exp);
        chk(log_addr[0] == 32'(a), "R3 first cycle address", log_addr[0], 32'(a));
        if (n == 4 && a % 2 == 0) begin
          chk(log_addr[1] == 32'(a + 2) && log_be[1] == 2'b11, "R4 aligned long second cycle",
              log_addr[1], 32'(a + 2));
          chk(log_dout[0] == {wd[7:0], wd[15:8]}, "R3 aligned lanes data", 32'(log_dout[0]),
              32'({wd[7:0], wd[15:8]}));
        end
        if (n == 2 && a % 2 != 0)
          chk(log_addr[1] == 32'(a + 1) && log_be[1] == 2'b10, "R5 unaligned word second byte",
              log_addr[1], 32'(a + 1));
        if (n == 4 && a % 2 != 0) begin
          chk(log_addr[1] == 32'(a + 1) && log_be[1] == 2'b11, "R6 unaligned long middle word",
              log_addr[1], 32'(a + 1));
          chk(log_addr[2] == 32'(a + 3) && log_be[2] == 2'b10, "R6 unaligned long last byte",
              log_addr[2], 32'(a + 3));
        end
        // read back
        run(2'd0, 1'b0, 32'(a), 2'(si), 32'h0);
        exp = 32'h0;
        for (int k = 0; k < n; k++) exp[k * 8 +: 8] = ref_mem[a + k];
        chk(got == exp, "R2 little-endian read value", got, exp);
        chk(n_stb == ncyc(a, n), "R4 R5 R6 read cycle count", 32'(n_stb), 32'(ncyc(a, n)));
        chk(lat == ncyc(a, n) + 1, "R9 read done latency", 32'(lat), 32'(ncyc(a, n) + 1));
      end
    end

    // R7 external I/O
    run(2'd1, 1'b1, 32'h0000_0105, 2'd0, 32'h0000_00A5);
    chk(n_stb == 1 && log_be[0] == 2'b01, "R7 io byte odd lane", 32'(log_be[0]), 32'd1);
    chk(log_dout[0][7:0] == 8'hA5, "R7 io byte data", 32'(log_dout[0]), 32'hA5);
    run(2'd1, 1'b1, 32'h0000_0104, 2'd0, 32'h0000_005A);
    chk(log_be[0] == 2'b10 && log_dout[0][15:8] == 8'h5A, "R7 io byte even lane",
        32'(log_dout[0]), 32'h5A00);
    run(2'd1, 1'b1, 32'h0000_0204, 2'd1, 32'h0000_1234);
    chk(n_stb == 1 && log_be[0] == 2'b11 && log_dout[0] == 16'h3412, "R7 io word",
        32'(log_dout[0]), 32'h3412);
    run(2'd1, 1'b1, 32'h0000_0207, 2'd2, 32'hDEAD_BEEF);
    chk(n_stb == 1, "R7 io long single cycle", 32'(n_stb), 32'd1);
    chk(log_be[0] == 2'b11 && log_dout[0] == 16'hEFBE, "R7 io long lanes",
        32'(log_dout[0]), 32'hEFBE);
    chk(bmem[6] == ref_mem[6] && bmem[7] == ref_mem[7], "R7 io write leaves memory",
        32'(bmem[7]), 32'(ref_mem[7]));
    run(2'd1, 1'b0, 32'h0000_0008, 2'd1, 32'h0);
    chk(got == {16'h0, ref_mem[9], ref_mem[8]}, "R7 io word read", got,
        {16'h0, ref_mem[9], ref_mem[8]});
    run(2'd3, 1'b0, 32'h0000_000B, 2'd0, 32'h0);
    chk(n_stb == 1 && got == {24'h0, ref_mem[11]}, "R7 io code 3 byte read", got,
        {24'h0, ref_mem[11]});

    // R8 on-chip I/O
    run(2'd2, 1'b1, 32'h1234_5610, 2'd0, 32'h0000_0077);
    chk(n_stb == 0 && n_quiet == 2, "R8 internal two quiet clocks", 32'(n_quiet), 32'd2);
    chk(q_addr == 32'h0000_0010 && q_be == 2'b00 && !q_stb, "R8 internal address",
        q_addr, 32'h10);
    chk(q_dout == 16'h7700, "R8 internal write lane", 32'(q_dout), 32'h7700);
    chk(lat == 3 && got == 32'h0, "R9 internal write done", 32'(lat), 32'd3);
    chk(bmem[16] == ref_mem[16], "R8 internal write leaves memory", 32'(bmem[16]), 32'(ref_mem[16]));
    run(2'd2, 1'b0, 32'hFFFF_FF14, 2'd2, 32'h0);
    chk(got == {24'h0, ref_mem[20]}, "R8 internal read upper lane", got, {24'h0, ref_mem[20]});
    chk(q_addr == 32'h0000_0014, "R8 internal address high bits zero", q_addr, 32'h14);

    @(negedge clk);
    chk(req_ready == 1'b1 && !bus_mem_stb && !bus_io_stb, "R1 idle after traffic",
        32'(req_ready), 32'd1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule